// File: doc/BRIEF.md
# Gain and Offset Trim Sequencer

This controller keeps an open-loop analog gain stage accurate by trimming it with two 7-bit correction DAC words, one for offset and one for fine gain. It owns the stage power control, the stage input multiplexer, the switch from the stage output to a shared ADC, the ADC enable and the calibration-voltage DAC. When a run starts, it powers the stage up, routes a known calibration voltage through the stage into the ADC, and repeats a loop of measure, compare and step by one code until each reading falls inside a tolerance window.

Offset is trimmed first against a mid-scale calibration voltage, where the ideal reading is zero. Gain is trimmed next against a second calibration voltage, where the ideal reading depends on the coarse gain the stage is set to. A run starts by itself after reset, again every fixed number of idle cycles, and whenever `cal_start` is pulsed. Between runs the block leaves the stage in normal signal mode with the ADC and the calibration DAC turned off. When a trim cannot reach its window, because a code would have to pass an end of its range or because the loop does not settle within its step budget, the run ends with a failure flag and the stage is still left in normal mode.

Top module: `gain_trim_sequencer`

## Requirements
- R1: While reset is low, the stage is powered down (`stage_pdn_n` = 0), `in_sel` = 00, `out_sw_en`, `adc_en`, `vcal_en`, `cal_done` and `cal_fail` are 0, and both codes hold `CODE_INIT` (64). A run starts with no request: `stage_pdn_n` and `cal_busy` are 1 one clock after reset is released.
- R2: Whenever `cal_busy` is 0, the ADC, the calibration DAC and the output switch are off and `in_sel` = 00 (signal input). Whenever the output switch is closed, the ADC and the calibration DAC are on and `in_sel` = 01 (calibration input).
- R3: `stage_pdn_n` is active low and, once high, stays high. The stage is powered for a full settle window before the calibration input is selected: `in_sel` changes to 01 exactly `settle_cycles` + 1 clocks after `stage_pdn_n` rises.
- R4: After each change of input routing, calibration voltage or correction code, ADC samples are ignored for `settle_cycles` clocks. The first sample that counts is the one presented with `adc_valid` on the clock after that window.
- R5: `in_sel` only takes the values 00 (signal) and 01 (calibration). The code 11 is never driven.
- R6: The ADC word is 8 bits with its top bit inverted. The bench forms the signed reading by inverting bit 7 and reading the result as two's complement. During the offset phase `vcal_code` = `VCAL_OFS` (128) and the target reading is 0. A reading above +`TOL` lowers `ofs_code` by one, a reading below −`TOL` raises it by one, and any reading inside ±`TOL` ends the phase.
- R7: During the gain phase `vcal_code` = `VCAL_GAIN` (192) and the target reading is `TGT_BASE` shifted left by `coarse_gain` (12, 24, 48 or 96). `gain_code` steps by one with the same direction rule, and a reading inside the window ends the run with `cal_done` = 1.
- R8: A correction code never wraps. It changes by exactly one per step and stays in 0 to 127. When the reading asks to go below 0 or above 127, the run ends at once with `cal_fail` = 1, the code holds at its end value, and the gain phase is skipped if the offset phase fails.
- R9: If a phase takes `MAX_ITER` (128) steps and the reading is still outside the window, the run ends with `cal_fail` = 1 and the code keeps its current value.
- R10: When the readings are already inside the window, a run ends with `cal_done` = 1 and leaves both codes unchanged.
- R11: A new run starts `PERIOD_CYC` clocks after `cal_busy` falls, with no request. A one-clock `cal_start` pulse while idle starts a run on the next clock. Codes change only while `cal_busy` is 1.
- R12: `cal_done` and `cal_fail` are never both 1. Both clear when a run starts, and exactly one of them is set when the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start | input | 1 | Request a run while idle |
| settle_cycles | input | SETTLE_W | Settle window length in clocks |
| coarse_gain | input | 2 | Coarse gain setting of the stage; selects the gain target |
| adc_data | input | ADC_W | ADC word, top bit inverted |
| adc_valid | input | 1 | ADC word valid strobe |
| stage_pdn_n | output | 1 | Stage power-down, active low |
| in_sel | output | 2 | Stage input multiplexer select |
| out_sw_en | output | 1 | Closes the stage-output-to-ADC switch |
| adc_en | output | 1 | ADC power enable |
| vcal_en | output | 1 | Calibration-voltage DAC power enable |
| vcal_code | output | VCAL_W | Calibration-voltage DAC word |
| gain_code | output | CODE_W | Fine-gain correction DAC word |
| ofs_code | output | CODE_W | Offset correction DAC word |
| cal_busy | output | 1 | A run is in progress |
| cal_done | output | 1 | Last run converged |
| cal_fail | output | 1 | Last run could not converge |

## Verification
Every control output comes straight from a register, so a routing change or a code step shows up one clock after the sample or request that caused it. The bench drives inputs and reads outputs on the falling edge. It measures the power-up-to-routing delay as `settle_cycles` + 1 falling edges, and the idle-to-periodic-start delay as exactly `PERIOD_CYC` falling edges after the first idle one. Its ADC model recomputes the reading from the current codes on every falling edge. The first sample the block may accept therefore lands on the clock after the settle window. In one run the model replaces exactly the `settle_cycles` samples that must be ignored with a large bogus value. Final codes and flags are checked on the first falling edge where `cal_busy` is low, against window limits the bench computes from each injected error.

// File: rtl/gts_pkg.sv
`timescale 1ns/1ps
package gts_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_POWER,
        ST_OFFSET,
        ST_GAIN,
        ST_NORMAL
    } gts_state_e;

    localparam logic [1:0] SEL_SIGNAL = 2'b00;
    localparam logic [1:0] SEL_CALV   = 2'b01;
endpackage

// File: rtl/gts_settle_timer.sv
`timescale 1ns/1ps
module gts_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         ready_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = len_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/gts_period_timer.sv
`timescale 1ns/1ps
module gts_period_timer #(
    parameter int PERIOD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic fire_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign fire_o = run_i && (cnt_q == LAST);

    always_comb begin
        if (run_i && !fire_o)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gts_sat_step.sv
`timescale 1ns/1ps
module gts_sat_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] code_i,
    input  logic         up_i,
    output logic [W-1:0] code_o,
    output logic         blocked_o
);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        blocked_o = up_i ? (code_i == TOP) : (code_i == '0);
        if (blocked_o)
            code_o = code_i;
        else if (up_i)
            code_o = code_i + 1'b1;
        else
            code_o = code_i - 1'b1;
    end
endmodule

// File: rtl/gain_trim_sequencer.sv
`timescale 1ns/1ps
module gain_trim_sequencer
    import gts_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int ADC_W      = 8,
    parameter int SETTLE_W   = 8,
    parameter int VCAL_W     = 8,
    parameter int PERIOD_CYC = 100000,
    parameter int MAX_ITER   = 128,
    parameter int TOL        = 1,
    parameter int CODE_INIT  = 64,
    parameter int VCAL_OFS   = 128,
    parameter int VCAL_GAIN  = 192,
    parameter int TGT_BASE   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [1:0]          coarse_gain,
    input  logic [ADC_W-1:0]    adc_data,
    input  logic                adc_valid,
    output logic                stage_pdn_n,
    output logic [1:0]          in_sel,
    output logic                out_sw_en,
    output logic                adc_en,
    output logic                vcal_en,
    output logic [VCAL_W-1:0]   vcal_code,
    output logic [CODE_W-1:0]   gain_code,
    output logic [CODE_W-1:0]   ofs_code,
    output logic                cal_busy,
    output logic                cal_done,
    output logic                cal_fail
);
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam int ERR_W  = ADC_W + 2;
    localparam logic signed [ERR_W-1:0] TOL_S     = ERR_W'(TOL);
    localparam logic [CODE_W-1:0]       CODE_RST  = CODE_W'(CODE_INIT);
    localparam logic [ITER_W-1:0]       ITER_LAST = ITER_W'(MAX_ITER);
    localparam int NUM_TRIM = 2;

    typedef struct packed {
        gts_state_e        st;
        logic [CODE_W-1:0] ofs;
        logic [CODE_W-1:0] gain;
        logic [ITER_W-1:0] iter;
        logic              done;
        logic              fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                     settle_load;
    logic                     settle_ready;
    logic                     period_fire;
    logic                     idle;
    logic                     measuring;
    logic                     use_gain;
    logic                     take_sample;
    logic signed [ADC_W-1:0]  sample;
    logic signed [ERR_W-1:0]  target;
    logic signed [ERR_W-1:0]  err;
    logic                     too_high;
    logic                     too_low;
    logic                     in_window;
    logic [CODE_W-1:0]        step_in  [NUM_TRIM];
    logic [CODE_W-1:0]        step_out [NUM_TRIM];
    logic [NUM_TRIM-1:0]      step_blocked;

    // Reading: top bit of the ADC word arrives inverted
    assign sample      = {~adc_data[ADC_W-1], adc_data[ADC_W-2:0]};
    assign use_gain    = (ctl_q.st == ST_GAIN);
    assign measuring   = (ctl_q.st == ST_OFFSET) || use_gain;
    assign idle        = (ctl_q.st == ST_NORMAL);
    assign target      = use_gain ? ERR_W'(TGT_BASE << coarse_gain) : '0;
    assign err         = ERR_W'(sample) - target;
    assign too_high    = err > TOL_S;
    assign too_low     = err < -TOL_S;
    assign in_window   = !too_high && !too_low;
    assign take_sample = measuring && settle_ready && adc_valid;

    assign step_in[0] = ctl_q.ofs;
    assign step_in[1] = ctl_q.gain;

    for (genvar gi = 0; gi < NUM_TRIM; gi++) begin : g_trim
        gts_sat_step #(.W(CODE_W)) u_step (
            .code_i   (step_in[gi]),
            .up_i     (too_low),
            .code_o   (step_out[gi]),
            .blocked_o(step_blocked[gi])
        );
    end

    gts_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (settle_load),
        .len_i  (settle_cycles),
        .ready_o(settle_ready)
    );

    gts_period_timer #(.PERIOD(PERIOD_CYC)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (idle),
        .fire_o(period_fire)
    );

    always_comb begin
        ctl_d       = ctl_q;
        settle_load = 1'b0;
        case (ctl_q.st)
            ST_BOOT: begin
                ctl_d.st    = ST_POWER;
                settle_load = 1'b1;
            end
            ST_POWER: begin
                if (settle_ready) begin
                    ctl_d.st    = ST_OFFSET;
                    ctl_d.iter  = '0;
                    settle_load = 1'b1;
                end
            end
            ST_OFFSET, ST_GAIN: begin
                if (take_sample) begin
                    if (in_window) begin
                        ctl_d.iter = '0;
                        if (use_gain) begin
                            ctl_d.st   = ST_NORMAL;
                            ctl_d.done = 1'b1;
                        end else begin
                            ctl_d.st    = ST_GAIN;
                            settle_load = 1'b1;
                        end
                    end else if (step_blocked[use_gain] || ctl_q.iter == ITER_LAST) begin
                        ctl_d.st   = ST_NORMAL;
                        ctl_d.fail = 1'b1;
                    end else begin
                        if (use_gain)
                            ctl_d.gain = step_out[1];
                        else
                            ctl_d.ofs = step_out[0];
                        ctl_d.iter  = ctl_q.iter + 1'b1;
                        settle_load = 1'b1;
                    end
                end
            end
            ST_NORMAL: begin
                if (cal_start || period_fire) begin
                    ctl_d.st    = ST_POWER;
                    ctl_d.done  = 1'b0;
                    ctl_d.fail  = 1'b0;
                    settle_load = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_NORMAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{st: ST_BOOT, ofs: CODE_RST, gain: CODE_RST,
                       iter: '0, done: 1'b0, fail: 1'b0};
        else
            ctl_q <= ctl_d;
    end

    assign stage_pdn_n = (ctl_q.st != ST_BOOT);
    assign in_sel      = measuring ? SEL_CALV : SEL_SIGNAL;
    assign out_sw_en   = measuring;
    assign adc_en      = measuring;
    assign vcal_en     = measuring;
    assign vcal_code   = (ctl_q.st == ST_OFFSET) ? VCAL_W'(VCAL_OFS) :
                         use_gain                ? VCAL_W'(VCAL_GAIN) : '0;
    assign gain_code   = ctl_q.gain;
    assign ofs_code    = ctl_q.ofs;
    assign cal_busy    = !idle;
    assign cal_done    = ctl_q.done;
    assign cal_fail    = ctl_q.fail;
endmodule

// File: rtl/gts_checker.sv
`timescale 1ns/1ps
module gts_checker
    import gts_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stage_pdn_n,
    input logic [1:0]        in_sel,
    input logic              out_sw_en,
    input logic              adc_en,
    input logic              vcal_en,
    input logic [CODE_W-1:0] gain_code,
    input logic [CODE_W-1:0] ofs_code,
    input logic              cal_busy,
    input logic              cal_done,
    input logic              cal_fail
);
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel != 2'b11); // R5

    AST_POWER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel == SEL_CALV) |-> stage_pdn_n); // R3

    AST_POWER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        stage_pdn_n |=> stage_pdn_n); // R3

    AST_CAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        out_sw_en |-> (adc_en && vcal_en && in_sel == SEL_CALV)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |-> (!out_sw_en && !adc_en && !vcal_en && in_sel == SEL_SIGNAL)); // R2

    AST_OFS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_code != $past(ofs_code)) |->
        (int'(ofs_code) == int'($past(ofs_code)) + 1 ||
         int'(ofs_code) == int'($past(ofs_code)) - 1)); // R8

    AST_GAIN_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != $past(gain_code)) |->
        (int'(gain_code) == int'($past(gain_code)) + 1 ||
         int'(gain_code) == int'($past(gain_code)) - 1)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |=> ($stable(ofs_code) && $stable(gain_code))); // R11

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done && cal_fail)); // R12
endmodule

bind gain_trim_sequencer gts_checker #(.CODE_W(CODE_W)) u_gts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_pdn_n(stage_pdn_n),
    .in_sel     (in_sel),
    .out_sw_en  (out_sw_en),
    .adc_en     (adc_en),
    .vcal_en    (vcal_en),
    .gain_code  (gain_code),
    .ofs_code   (ofs_code),
    .cal_busy   (cal_busy),
    .cal_done   (cal_done),
    .cal_fail   (cal_fail)
);

// File: tb/gain_trim_sequencer_test.sv
`timescale 1ns/1ps
module gain_trim_sequencer_test;
    localparam int PERIOD_CYC = 3000;
    localparam int TOL        = 1;
    localparam int VCAL_OFS   = 128;
    localparam int TGT_BASE   = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic [7:0] settle_cycles = 8'd3;
    logic [1:0] coarse_gain = 2'd0;
    logic [7:0] adc_data = 8'h80;
    logic       adc_valid = 1'b0;
    logic       stage_pdn_n;
    logic [1:0] in_sel;
    logic       out_sw_en, adc_en, vcal_en;
    logic [7:0] vcal_code;
    logic [6:0] gain_code, ofs_code;
    logic       cal_busy, cal_done, cal_fail;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int m_eo = 0, m_eg = 0;
    bit m_osc = 0, m_glitch = 0;
    bit sw_seen = 0;
    int glitch_left = 0;
    int s_val;
    int exp_ofs = 64, exp_gain = 64;

    always #2.5 clk = ~clk;

    gain_trim_sequencer #(.PERIOD_CYC(PERIOD_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .settle_cycles(settle_cycles), .coarse_gain(coarse_gain),
        .adc_data(adc_data), .adc_valid(adc_valid),
        .stage_pdn_n(stage_pdn_n), .in_sel(in_sel), .out_sw_en(out_sw_en),
        .adc_en(adc_en), .vcal_en(vcal_en), .vcal_code(vcal_code),
        .gain_code(gain_code), .ofs_code(ofs_code),
        .cal_busy(cal_busy), .cal_done(cal_done), .cal_fail(cal_fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural stage + ADC: reading follows the current correction codes
    always @(negedge clk) begin
        if (!out_sw_en) sw_seen = 1'b0;
        if (out_sw_en && !sw_seen) begin
            sw_seen = 1'b1;
            glitch_left = m_glitch ? int'(settle_cycles) : 0;
        end
        if (adc_en && out_sw_en) begin
            if (int'(vcal_code) == VCAL_OFS)
                s_val = m_osc ? (ofs_code[0] ? 50 : -50) : m_eo + int'(ofs_code) - 64;
            else
                s_val = (TGT_BASE << coarse_gain) + m_eg + int'(gain_code) - 64;
            if (glitch_left > 0) begin
                s_val = 100;
                glitch_left--;
            end
            if (s_val > 127)  s_val = 127;
            if (s_val < -128) s_val = -128;
            adc_data  = {~s_val[7], s_val[6:0]};
            adc_valid = 1'b1;
        end else begin
            adc_valid = 1'b0;
        end
    end

    function automatic int win_code(input int c0, input int e);
        int lo = 64 - e - TOL;
        int hi = 64 - e + TOL;
        if (hi < 0)   return 0;
        if (lo > 127) return 127;
        if (c0 < lo)  return lo;
        if (c0 > hi)  return hi;
        return c0;
    endfunction

    function automatic bit win_fail(input int e);
        return (64 - e + TOL < 0) || (64 - e - TOL > 127);
    endfunction

    task automatic wait_idle();
        while (cal_busy) @(negedge clk);
    endtask

    task automatic check_idle_state(input bit ef);
        check(cal_done == !ef, "R12 done flag", int'(cal_done), int'(!ef));
        check(cal_fail == ef, "R12 fail flag", int'(cal_fail), int'(ef));
        check(!out_sw_en && !adc_en && !vcal_en, "R2 normal mode quiet",
              int'({out_sw_en, adc_en, vcal_en}), 0);
        check(in_sel == 2'b00, "R5 signal input selected", int'(in_sel), 0);
        check(stage_pdn_n == 1'b1, "R3 stage stays powered", int'(stage_pdn_n), 1);
    endtask

    task automatic run_cal(input int eo, input int eg, input int cg, input bit osc);
        bit ef;
        m_eo = eo; m_eg = eg; m_osc = osc; m_glitch = 1'b0;
        coarse_gain = cg[1:0];
        @(negedge clk) cal_start = 1'b1;
        @(negedge clk) cal_start = 1'b0;
        check(cal_busy && !cal_done && !cal_fail, "R12 flags cleared at start",
              int'({cal_busy, cal_done, cal_fail}), 4);
        wait_idle();
        ef = 1'b0;
        if (osc) begin
            ef = 1'b1;
        end else if (win_fail(eo)) begin
            ef = 1'b1;
            exp_ofs = win_code(exp_ofs, eo);
        end else begin
            exp_ofs = win_code(exp_ofs, eo);
            ef = win_fail(eg);
            exp_gain = win_code(exp_gain, eg);
        end
        if (osc)
            check(int'(ofs_code) == exp_ofs, "R9 code held at iteration limit", int'(ofs_code), exp_ofs);
        else if (ef && win_fail(eo))
            check(int'(ofs_code) == exp_ofs, "R8 offset saturates", int'(ofs_code), exp_ofs);
        else
            check(int'(ofs_code) == exp_ofs, "R6 offset code", int'(ofs_code), exp_ofs);
        if (!osc && !win_fail(eo) && win_fail(eg))
            check(int'(gain_code) == exp_gain, "R8 gain saturates", int'(gain_code), exp_gain);
        else
            check(int'(gain_code) == exp_gain, "R7 gain code", int'(gain_code), exp_gain);
        check_idle_state(ef);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            vectors++;
            errors++;
            $display("FAIL R11 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int o_prev, g_prev;
        int eg_list [5] = '{-75, -9, 0, 40, 70};
        m_glitch = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(stage_pdn_n == 1'b0, "R1 stage powered down in reset", int'(stage_pdn_n), 0);
        check(in_sel == 2'b00 && !out_sw_en && !adc_en && !vcal_en, "R1 routing in reset",
              int'({in_sel, out_sw_en, adc_en, vcal_en}), 0);
        check(ofs_code == 7'd64 && gain_code == 7'd64, "R1 codes at mid-scale",
              int'(ofs_code), 64);
        check(!cal_done && !cal_fail, "R1 flags clear in reset", int'({cal_done, cal_fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stage_pdn_n && cal_busy, "R1 automatic first run", int'({stage_pdn_n, cal_busy}), 3);
        n = 0;
        while (in_sel != 2'b01 && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == int'(settle_cycles) + 1, "R3 power-up precedes cal routing", n, int'(settle_cycles) + 1);
        check(int'(vcal_code) == VCAL_OFS, "R6 offset calibration voltage", int'(vcal_code), VCAL_OFS);
        wait_idle();
        // zero error with bogus samples inside the settle window
        check(ofs_code == 7'd64, "R4 samples during settle ignored", int'(ofs_code), 64);
        check(gain_code == 7'd64, "R10 zero error keeps gain code", int'(gain_code), 64);
        check_idle_state(1'b0);
        m_glitch = 1'b0;
        settle_cycles = 8'd2;

        // R10: a trimmed stage is not disturbed by a repeat run
        run_cal(25, -12, 2, 1'b0);
        o_prev = int'(ofs_code);
        g_prev = int'(gain_code);
        run_cal(25, -12, 2, 1'b0);
        check(int'(ofs_code) == o_prev, "R10 repeat run keeps offset", int'(ofs_code), o_prev);
        check(int'(gain_code) == g_prev, "R10 repeat run keeps gain", int'(gain_code), g_prev);

        // sweep over coarse gain, offset error and gain error
        for (int cg = 0; cg < 4; cg++) begin
            for (int eo = -70; eo <= 70; eo += 20) begin
                for (int k = 0; k < 5; k++) begin
                    run_cal(eo, eg_list[k], cg, 1'b0);
                end
            end
        end

        // R9: oscillating reading hits the step budget
        run_cal(0, 0, 0, 1'b1);

        // R11: periodic restart after a clean run
        run_cal(3, -4, 1, 1'b0);
        o_prev = int'(ofs_code);
        g_prev = int'(gain_code);
        n = 0;
        while (!cal_busy && n < PERIOD_CYC + 10) begin
            @(negedge clk);
            n++;
        end
        check(n == PERIOD_CYC, "R11 periodic restart interval", n, PERIOD_CYC);
        wait_idle();
        check(int'(ofs_code) == o_prev && int'(gain_code) == g_prev,
              "R11 periodic run keeps trimmed codes", int'(ofs_code), o_prev);
        check_idle_state(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule